// File: doc/BRIEF.md
# MDIO Management Interface Master

This block is a serial management master for external Ethernet PHY devices. A host presents a single-cycle command that chooses one of two device windows and gives a 5-bit register number, a read/write flag and 16 bits of write data. The block generates the management clock from the system clock and shifts out a complete clause-22 style frame, most significant bit first. On reads it hands the data line over to the PHY during the turnaround and samples the 16-bit reply. When the frame ends it pulses `done` and, on reads, presents the received word on `rd_data`.

The PHY address is not part of the command. Each device window owns a 5-bit address register that the host programs through a separate write strobe. The register that belongs to the chosen window supplies the PHY address field of the frame, so either window can reach any of 32 PHY addresses.

The pad is not part of the block. The data line is exposed as an output value, an output enable and an input, and the input passes through a two-stage synchronizer before it is used.

Top module: `mdio_master`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the block returns to idle: after that edge `busy`, `done`, `mdio_oe` and `mdc` are all 0. This also aborts a frame that is in progress.
- R2: Whenever `busy` is 0, `mdc` is held at 0 and `mdio_oe` is 0, so the line is released between frames.
- R3: A command is accepted only at a clock edge where `cmd_valid` is 1 and `busy` is 0. `busy` is 1 from the cycle after acceptance up to and including the cycle before `done`. A `cmd_valid` raised while `busy` is 1 has no effect on the frame in progress and starts no later frame.
- R4: Each frame has 64 bits, sent MSB first with one bit per MDC period:
  - 32 ones;
  - start bits 0 then 1;
  - opcode 0,1 for a write or 1,0 for a read;
  - 5-bit PHY address;
  - 5-bit register number;
  - 2 turnaround bits;
  - 16 data bits.
- R5: `addr_wr_en` loads `addr_wr_data` into the address register chosen by `addr_wr_sel`. A frame for `cmd_dev`=0 carries the value of register 0 in its PHY address field. A frame for `cmd_dev`=1 carries the value of register 1. Both registers reset to 0.
- R6: On a write, the turnaround bits are 1 then 0 and `mdio_oe` stays 1 for all 64 bits.
- R7: On a read, `mdio_oe` is 1 for bits 0 to 45 and 0 from the first turnaround bit (bit 46) to the end of the frame. The 16 data bits are sampled from the synchronized `mdio_in` at each rising MDC edge in bits 48 to 63 and appear on `rd_data` together with `done`. A write leaves `rd_data` unchanged.
- R8: While busy, `mdc` is low for DIV_HALF clocks and then high for DIV_HALF clocks, giving 64 full periods per frame. `mdio_out` and `mdio_oe` change only in the cycle where `mdc` falls or in the cycle where `busy` rises.
- R9: `done` is a one-cycle pulse. It is high in the cycle that starts exactly 128*DIV_HALF clock edges after the accepting edge, and `busy` is 0 in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addr_wr_en | input | 1 | Load strobe for a PHY address register |
| addr_wr_sel | input | 1 | Which address register to load |
| addr_wr_data | input | 5 | PHY address value to load |
| cmd_valid | input | 1 | Command request, honoured only when idle |
| cmd_dev | input | 1 | Device window of the command |
| cmd_reg | input | 5 | PHY register number |
| cmd_read | input | 1 | 1 for a read, 0 for a write |
| cmd_wdata | input | 16 | Data for a write |
| busy | output | 1 | Frame in progress |
| done | output | 1 | One-cycle end-of-frame pulse |
| rd_data | output | 16 | Data returned by the last read |
| mdc | output | 1 | Management clock |
| mdio_out | output | 1 | Data value driven toward the line |
| mdio_oe | output | 1 | Drive enable for the line |
| mdio_in | input | 1 | Line value seen at the pad |

## Verification
Every result is due a fixed number of clock edges after the accepting edge. `busy` is due one edge after it. MDC toggles every DIV_HALF edges. `done` and `rd_data` are due exactly 128*DIV_HALF edges after it. The bench counts clock edges from the accepting edge and samples on falling clock edges. It checks `busy` at every sample before that count and checks `done`, `busy` and the line state at exactly that count. The frame bits are captured on each rising edge of `mdc`, which lies half an MDC period away from any change of `mdio_out`. A bench PHY model changes `mdio_in` just after each falling MDC edge. This leaves the synchronizer its two cycles before the next rising edge.

// File: rtl/mdio_pkg.sv
// Package: field widths, frame layout and frame builder for the MDIO master.
// Assumes clause-22 framing with a fixed 64-bit frame.
package mdio_pkg;
    localparam int PRE_LEN    = 32;
    localparam int PHY_W      = 5;
    localparam int REG_W      = 5;
    localparam int DATA_W     = 16;
    localparam int FRAME_LEN  = PRE_LEN + 2 + 2 + PHY_W + REG_W + 2 + DATA_W;
    localparam int TA_POS     = PRE_LEN + 4 + PHY_W + REG_W;
    localparam int DATA_POS   = TA_POS + 2;
    localparam int IDX_W      = $clog2(FRAME_LEN);

    localparam logic [1:0] SOF_BITS = 2'b01;
    localparam logic [1:0] OP_WRITE = 2'b01;
    localparam logic [1:0] OP_READ  = 2'b10;
    localparam logic [1:0] TA_WRITE = 2'b10;

    // Assemble the full frame, first bit in the MSB position.
    function automatic logic [FRAME_LEN-1:0] build_frame(
        input logic              rd,
        input logic [PHY_W-1:0]  phy,
        input logic [REG_W-1:0]  rg,
        input logic [DATA_W-1:0] wd
    );
        build_frame = {{PRE_LEN{1'b1}}, SOF_BITS,
                       (rd ? OP_READ : OP_WRITE), phy, rg,
                       (rd ? 2'b00 : TA_WRITE),
                       (rd ? {DATA_W{1'b0}} : wd)};
    endfunction
endpackage

// File: rtl/mdio_addr_bank.sv
// Module: mdio_addr_bank
// Holds one PHY address register per device window and returns the one
// chosen by the current command. Assumes writes come one at a time.
module mdio_addr_bank #(
    parameter int NUM_DEV = 2,
    parameter int PHY_W   = 5,
    localparam int SEL_W  = (NUM_DEV > 1) ? $clog2(NUM_DEV) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [SEL_W-1:0] wr_sel,
    input  logic [PHY_W-1:0] wr_data,
    input  logic [SEL_W-1:0] rd_sel,
    output logic [PHY_W-1:0] rd_addr
);
    logic [PHY_W-1:0] slot_q [NUM_DEV];

    for (genvar g = 0; g < NUM_DEV; g++) begin : g_slot
        // Load this window's address register on a matching write strobe.
        always_ff @(posedge clk) begin
            if (!rst_n)
                slot_q[g] <= '0;
            else if (wr_en && (wr_sel == SEL_W'(g)))
                slot_q[g] <= wr_data;
        end
    end

    // Select the address for the window named by the command.
    always_comb begin
        rd_addr = '0;
        for (int i = 0; i < NUM_DEV; i++)
            if (rd_sel == SEL_W'(i)) rd_addr = slot_q[i];
    end
endmodule

// File: rtl/mdio_clkgen.sv
// Module: mdio_clkgen
// Divides the system clock to make MDC while enabled and flags the clock
// cycles in which MDC rises or falls. Assumes DIV_HALF >= 3 so that the
// input synchronizer settles within one MDC half period.
module mdio_clkgen #(
    parameter int DIV_HALF = 4,
    localparam int CNT_W   = (DIV_HALF > 1) ? $clog2(DIV_HALF) : 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic mdc,
    output logic rise_tk,
    output logic fall_tk
);
    logic [CNT_W-1:0] cnt_q;
    logic             wrap;

    assign wrap    = en && (cnt_q == CNT_W'(DIV_HALF - 1));
    assign rise_tk = wrap && !mdc;
    assign fall_tk = wrap && mdc;

    // Count half periods and toggle MDC; park low when disabled.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            cnt_q <= '0;
            mdc   <= 1'b0;
        end else if (wrap) begin
            cnt_q <= '0;
            mdc   <= !mdc;
        end else begin
            cnt_q <= cnt_q + CNT_W'(1);
        end
    end
endmodule

// File: rtl/mdio_frame_engine.sv
// Module: mdio_frame_engine
// Accepts a command when idle, shifts the frame out on MDC falling ticks,
// releases the line for read turnaround and captures read data on rising
// ticks. Assumes mdio_in_s is already synchronized.
module mdio_frame_engine
    import mdio_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic              cmd_read,
    input  logic [PHY_W-1:0]  cmd_phy,
    input  logic [REG_W-1:0]  cmd_reg,
    input  logic [DATA_W-1:0] cmd_wdata,
    input  logic              rise_tk,
    input  logic              fall_tk,
    input  logic              mdio_in_s,
    output logic              busy,
    output logic              done,
    output logic [DATA_W-1:0] rd_data,
    output logic              mdio_out,
    output logic              mdio_oe
);
    localparam logic [IDX_W-1:0] LAST_BIT = IDX_W'(FRAME_LEN - 1);

    logic [FRAME_LEN-1:0] tx_sr;
    logic [DATA_W-1:0]    rx_sr;
    logic [IDX_W-1:0]     bit_idx;
    logic [IDX_W-1:0]     next_idx;
    logic                 is_read;
    logic                 accept;

    assign accept   = cmd_valid && !busy;
    assign next_idx = bit_idx + IDX_W'(1);

    // Frame sequencing: load, shift, release and finish.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy     <= 1'b0;
            done     <= 1'b0;
            tx_sr    <= '0;
            bit_idx  <= '0;
            is_read  <= 1'b0;
            mdio_out <= 1'b0;
            mdio_oe  <= 1'b0;
        end else begin
            done <= 1'b0;
            if (accept) begin
                tx_sr    <= build_frame(cmd_read, cmd_phy, cmd_reg, cmd_wdata);
                is_read  <= cmd_read;
                bit_idx  <= '0;
                busy     <= 1'b1;
                mdio_oe  <= 1'b1;
                mdio_out <= 1'b1;
            end else if (busy && fall_tk) begin
                if (bit_idx == LAST_BIT) begin
                    busy     <= 1'b0;
                    done     <= 1'b1;
                    mdio_oe  <= 1'b0;
                    mdio_out <= 1'b0;
                end else begin
                    bit_idx  <= next_idx;
                    tx_sr    <= {tx_sr[FRAME_LEN-2:0], 1'b0};
                    mdio_oe  <= !is_read || (next_idx < IDX_W'(TA_POS));
                    mdio_out <= (!is_read || (next_idx < IDX_W'(TA_POS)))
                                ? tx_sr[FRAME_LEN-2] : 1'b0;
                end
            end
        end
    end

    // Capture reply bits during the data field of a read.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rx_sr <= '0;
        else if (busy && is_read && rise_tk && (bit_idx >= IDX_W'(DATA_POS)))
            rx_sr <= {rx_sr[DATA_W-2:0], mdio_in_s};
    end

    // Publish read data at the end of a read frame.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rd_data <= '0;
        else if (busy && fall_tk && (bit_idx == LAST_BIT) && is_read)
            rd_data <= rx_sr;
    end

    // R9: done lasts a single cycle.
    a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R9: busy is already low while done is high.
    a_r9_busy_low_at_done: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);
    // R2: the line is released whenever no frame runs.
    a_r2_released_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mdio_oe);
    // R3: a request during a frame does not alter the latched command.
    a_r3_cmd_held_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> (!busy || ($stable(is_read) && $stable(bit_idx) == !$past(fall_tk))));
endmodule

// File: rtl/mdio_master.sv
// Module: mdio_master (top)
// MDIO management master: two PHY address windows, MDC generation, frame
// engine and input synchronizer. Assumes the pad buffer is external and
// driven by mdio_out / mdio_oe.
module mdio_master
    import mdio_pkg::*;
#(
    parameter int DIV_HALF = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              addr_wr_en,
    input  logic              addr_wr_sel,
    input  logic [PHY_W-1:0]  addr_wr_data,
    input  logic              cmd_valid,
    input  logic              cmd_dev,
    input  logic [REG_W-1:0]  cmd_reg,
    input  logic              cmd_read,
    input  logic [DATA_W-1:0] cmd_wdata,
    output logic              busy,
    output logic              done,
    output logic [DATA_W-1:0] rd_data,
    output logic              mdc,
    output logic              mdio_out,
    output logic              mdio_oe,
    input  logic              mdio_in
);
    localparam int SYNC_DEPTH = 2;

    logic [PHY_W-1:0]      sel_phy;
    logic                  rise_tk;
    logic                  fall_tk;
    logic [SYNC_DEPTH-1:0] in_sync;

    // Bring the pad input into the clock domain through two flops.
    always_ff @(posedge clk) begin
        if (!rst_n)
            in_sync <= '1;
        else
            in_sync <= {in_sync[SYNC_DEPTH-2:0], mdio_in};
    end

    mdio_addr_bank #(.NUM_DEV(2), .PHY_W(PHY_W)) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (addr_wr_en),
        .wr_sel  (addr_wr_sel),
        .wr_data (addr_wr_data),
        .rd_sel  (cmd_dev),
        .rd_addr (sel_phy)
    );

    mdio_clkgen #(.DIV_HALF(DIV_HALF)) u_clk (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (busy),
        .mdc     (mdc),
        .rise_tk (rise_tk),
        .fall_tk (fall_tk)
    );

    mdio_frame_engine u_eng (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_valid (cmd_valid),
        .cmd_read  (cmd_read),
        .cmd_phy   (sel_phy),
        .cmd_reg   (cmd_reg),
        .cmd_wdata (cmd_wdata),
        .rise_tk   (rise_tk),
        .fall_tk   (fall_tk),
        .mdio_in_s (in_sync[SYNC_DEPTH-1]),
        .busy      (busy),
        .done      (done),
        .rd_data   (rd_data),
        .mdio_out  (mdio_out),
        .mdio_oe   (mdio_oe)
    );

    // R2: MDC rests low outside a frame.
    a_r2_mdc_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mdc);
    // R8: line outputs move only on an MDC fall or at frame start.
    a_r8_change_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$fell(mdc) && !$rose(busy))
            |-> ($stable(mdio_out) && $stable(mdio_oe)));
endmodule

// File: tb/mdio_master_bench.sv
module mdio_master_bench;
    localparam int H   = 4;
    localparam int LAT = 128 * H;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        addr_wr_en = 1'b0;
    logic        addr_wr_sel = 1'b0;
    logic [4:0]  addr_wr_data = '0;
    logic        cmd_valid = 1'b0;
    logic        cmd_dev = 1'b0;
    logic [4:0]  cmd_reg = '0;
    logic        cmd_read = 1'b0;
    logic [15:0] cmd_wdata = '0;
    logic        busy, done, mdc, mdio_out, mdio_oe;
    logic [15:0] rd_data;
    logic        mdio_in = 1'b1;

    int n_chk = 0;
    int n_fail = 0;

    always #5 clk = !clk;

    mdio_master #(.DIV_HALF(H)) u_mdio_master (
        .clk(clk), .rst_n(rst_n),
        .addr_wr_en(addr_wr_en), .addr_wr_sel(addr_wr_sel), .addr_wr_data(addr_wr_data),
        .cmd_valid(cmd_valid), .cmd_dev(cmd_dev), .cmd_reg(cmd_reg),
        .cmd_read(cmd_read), .cmd_wdata(cmd_wdata),
        .busy(busy), .done(done), .rd_data(rd_data),
        .mdc(mdc), .mdio_out(mdio_out), .mdio_oe(mdio_oe), .mdio_in(mdio_in)
    );

    // Bench PHY: capture each bit at the rising MDC edge.
    logic        cap_bit [64];
    logic        cap_oe  [64];
    int          cap_n = 0;
    logic [15:0] phy_reply = '0;

    always @(posedge mdc) begin
        if (cap_n < 64) begin
            cap_bit[cap_n] = mdio_out;
            cap_oe[cap_n]  = mdio_oe;
        end
        cap_n = cap_n + 1;
    end

    // Bench PHY: drive the reply after each falling MDC edge on reads.
    always @(negedge mdc) begin
        #1;
        if (cap_n >= 47 && cap_n <= 63 && cap_bit[34] && !cap_bit[35])
            mdio_in = (cap_n == 47) ? 1'b0 : phy_reply[63 - cap_n];
        else
            mdio_in = 1'b1;
    end

    task automatic chk(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); @(negedge clk); rst_n = 1'b1;
    endtask

    task automatic set_addr(input logic sel, input logic [4:0] val);
        @(negedge clk);
        addr_wr_en = 1'b1; addr_wr_sel = sel; addr_wr_data = val;
        @(negedge clk);
        addr_wr_en = 1'b0;
    endtask

    // Run one frame, check timing, busy, MDC and the captured bits.
    task automatic run_frame(input logic dev, input logic [4:0] rg, input logic rd,
                             input logic [15:0] wd, input logic [4:0] exp_phy,
                             input bit inject, input string tag);
        logic [63:0] exp_f, got_f, exp_oe, got_oe;
        logic [15:0] rd_before;
        int cnt, hi_cnt, busy_bad;
        rd_before = rd_data;
        cap_n = 0;
        @(negedge clk);
        cmd_valid = 1'b1; cmd_dev = dev; cmd_reg = rg; cmd_read = rd; cmd_wdata = wd;
        @(negedge clk);
        cmd_valid = 1'b0;
        cnt = 0; hi_cnt = 0; busy_bad = 0;
        while (cnt < LAT + 10) begin
            if (!busy) busy_bad++;
            if (mdc) hi_cnt++;
            @(negedge clk); cnt++;
            if (inject && cnt == 50) begin
                cmd_valid = 1'b1; cmd_dev = !dev; cmd_reg = ~rg; cmd_read = !rd;
                cmd_wdata = ~wd;
            end
            if (inject && cnt == 51) cmd_valid = 1'b0;
            if (done) break;
        end
        // R9: done arrives exactly 128*H edges after acceptance.
        chk(cnt == LAT, {tag, " R9 latency"}, cnt, LAT);
        chk(!busy, {tag, " R9 busy low with done"}, busy, 0);
        // R3: busy held for the whole frame.
        chk(busy_bad == 0, {tag, " R3 busy gaps"}, busy_bad, 0);
        // R8: 64 MDC periods, each high for H clocks.
        chk(hi_cnt == 64 * H, {tag, " R8 mdc high clocks"}, hi_cnt, 64 * H);
        chk(cap_n == 64, {tag, " R8 mdc rising edges"}, cap_n, 64);
        // R2: idle state right after the frame.
        chk(!mdio_oe && !mdc, {tag, " R2 released after frame"}, {mdio_oe, mdc}, 0);
        for (int i = 0; i < 64; i++) begin
            got_f[63 - i]  = cap_bit[i];
            got_oe[63 - i] = cap_oe[i];
        end
        exp_f = {32'hFFFF_FFFF, 2'b01, (rd ? 2'b10 : 2'b01), exp_phy, rg,
                 (rd ? 2'b00 : 2'b10), (rd ? 16'h0 : wd)};
        exp_oe = rd ? {{46{1'b1}}, 18'h0} : {64{1'b1}};
        // R4 / R5: header fields and PHY address of the chosen window.
        chk(got_f[63:18] == exp_f[63:18], {tag, " R4 header bits"}, got_f[63:18], exp_f[63:18]);
        chk(got_f[27:23] == exp_phy, {tag, " R5 phy field"}, got_f[27:23], exp_phy);
        if (rd) begin
            // R7: released from bit 46, reply captured.
            chk(got_oe == exp_oe, {tag, " R7 oe pattern"}, got_oe, exp_oe);
            chk(rd_data == phy_reply, {tag, " R7 read data"}, rd_data, phy_reply);
        end else begin
            // R6: turnaround 1,0 and full drive; R7: rd_data kept.
            chk(got_f == exp_f, {tag, " R6 write frame"}, got_f, exp_f);
            chk(got_oe == exp_oe, {tag, " R6 oe pattern"}, got_oe, exp_oe);
            chk(rd_data == rd_before, {tag, " R7 rd_data kept on write"}, rd_data, rd_before);
        end
        @(negedge clk);
        chk(!done, {tag, " R9 done one cycle"}, done, 0);
        repeat (2 * H + 4) @(negedge clk);
        // R3: no deferred frame from an ignored request.
        chk(!busy && !mdc, {tag, " R3 stays idle"}, {busy, mdc}, 0);
    endtask

    task automatic t_reset_state();
        do_reset();
        chk({busy, done, mdio_oe, mdc} == 4'b0, "R1 reset state",
            {busy, done, mdio_oe, mdc}, 0);
    endtask

    task automatic t_writes();
        set_addr(1'b0, 5'h05);
        set_addr(1'b1, 5'h1A);
        run_frame(1'b0, 5'h03, 1'b0, 16'hA5C3, 5'h05, 1'b0, "wr dev0");
        run_frame(1'b1, 5'h1F, 1'b0, 16'hFFFF, 5'h1A, 1'b0, "wr dev1 max reg");
    endtask

    task automatic t_reads();
        phy_reply = 16'h8001;
        run_frame(1'b0, 5'h00, 1'b1, 16'h0, 5'h05, 1'b0, "rd dev0");
        phy_reply = 16'h5AF0;
        set_addr(1'b1, 5'h1F);
        run_frame(1'b1, 5'h11, 1'b1, 16'h0, 5'h1F, 1'b0, "rd dev1 addr31");
    endtask

    task automatic t_busy_ignore();
        phy_reply = 16'h1234;
        run_frame(1'b0, 5'h09, 1'b0, 16'h0F0F, 5'h05, 1'b1, "ignore during busy");
    endtask

    task automatic t_midframe_reset();
        @(negedge clk);
        cmd_valid = 1'b1; cmd_dev = 1'b0; cmd_reg = 5'h02; cmd_read = 1'b0;
        @(negedge clk);
        cmd_valid = 1'b0;
        repeat (300) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk({busy, done, mdio_oe, mdc} == 4'b0, "R1 abort mid frame",
            {busy, done, mdio_oe, mdc}, 0);
        rst_n = 1'b1;
        repeat (3 * H) @(negedge clk);
        chk(!busy && !mdc && !mdio_oe, "R2 idle after abort", {busy, mdc, mdio_oe}, 0);
        // R5: address registers return to 0 after reset.
        run_frame(1'b1, 5'h04, 1'b0, 16'h00FF, 5'h00, 1'b0, "R5 addr after reset");
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end

    initial begin
        t_reset_state();
        t_writes();
        t_reads();
        t_busy_ignore();
        t_midframe_reset();
        finish_run();
    end
endmodule